// File: doc/BRIEF.md
# Programmable Timer Counter with Match

This block is one timer channel controlled through a small register bus. A count register advances on timer ticks, which come from a clock-enable input or from edges of an external clock line. An optional prescaler divides those ticks by a power of two. The counter counts up or down. In free-running mode it wraps across the full counter width. In interval mode it wraps at a programmed limit.

Three compare registers are checked against the count. Interval wraps, overflow wraps and compare hits each set their own sticky status bit. An enable mask decides which status bits drive the interrupt line. Compare hits on the first compare register can toggle a waveform output. That output has selectable polarity and a disable bit. The counter width is the parameter `CW`, which is 16 or 32.

Writes take effect on the clock edge where `bus_wr` is high. Reads are strobed by `bus_rd`. Read data is registered and is valid, with `bus_rvalid` high, in the cycle that follows the strobe. The bus is always ready and has no back-pressure.

Top module: `tmr_match_chan`

## Requirements
- R1: After reset the counter-control register reads 0x21 (stopped, waveform disabled). The count reads 0, status reads 0, and `irq` and `wave_out` are low.
- R2: Register offsets are: 0x00 source/prescale control, 0x0C counter control, 0x18 count, 0x24 interval, 0x30/0x3C/0x48 compare 0/1/2, 0x54 status, 0x60 interrupt enable. Read data appears with `bus_rvalid` one cycle after `bus_rd`. The count register is read-only, and a write to it has no effect.
- R3: With counter-control bit 0 (stop) clear, each qualified tick changes the count by one. With stop set, the count holds.
- R4: With counter-control bit 2 set, the counter counts down. In free-running mode it wraps from 0 to 2^CW-1.
- R5: In free-running mode (counter-control bit 1 clear), a wrap across the full width sets status bit 4.
- R6: In interval mode (bit 1 set), counting up from the interval value goes to 0, and counting down from 0 goes to the interval value. Either wrap sets status bit 0.
- R7: Writing counter-control bit 4 as 1 loads the count: 0 when the written bit 2 is clear, otherwise the interval value. It also restarts the prescaler. Bit 4 always reads back 0.
- R8: With source-control bit 0 set, the count advances once every 2^(N+1) ticks, where N is source-control bits 4:1. With bit 0 clear, it advances on every tick.
- R9: With source-control bit 5 set, ticks are edges of `ext_clk`, seen through a two-flop synchronizer while `tmr_en` is high. Bit 6 clear selects rising edges and bit 6 set selects falling edges.
- R10: With counter-control bit 3 set, a count reaching compare i sets status bit i+1. With bit 3 clear, compare hits set no status bit.
- R11: Status bits stay set until the status register is read. The read returns the value from before the clear.
- R12: `irq` is high exactly when some status bit is set and its bit in the interrupt-enable register is set.
- R13: While counter-control bit 3 is set, each hit on compare 0 toggles an internal wave state. `wave_out` is that state XOR bit 6, and it is forced low while bit 5 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| tmr_en | input | 1 | Timer clock enable; every tick source is qualified by it |
| ext_clk | input | 1 | External clock line, asynchronous |
| irq | output | 1 | Masked interrupt |
| wave_out | output | 1 | Waveform output |

## Verification
The hardest case to reach is the full-width up-count overflow. The count register cannot be written, so the only way there is to deliver 2^CW ticks. The bench holds the tick enable for 65537 cycles from a restart and then expects a count of 1 with the overflow bit set.

The edge-select case is also tricky, because any symmetric toggle pattern gives the same count for either edge. The bench therefore drives patterns in which the selected edge occurs one more time than the other edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [7:0] A_SRC  = 8'h00;
  localparam logic [7:0] A_CTL  = 8'h0C;
  localparam logic [7:0] A_CNT  = 8'h18;
  localparam logic [7:0] A_INTV = 8'h24;
  localparam logic [7:0] A_CMP0 = 8'h30;
  localparam logic [7:0] A_STAT = 8'h54;
  localparam logic [7:0] A_MASK = 8'h60;
  localparam int CMP_STRIDE = 12;
  localparam int NUM_CMP    = 3;
  localparam int NUM_EV     = NUM_CMP + 2;
  localparam int EV_WRAP    = 0;
  localparam int EV_OVF     = NUM_CMP + 1;
  localparam logic [6:0] CTL_RST = 7'h21;

  typedef struct packed {
    logic       edge_fall;
    logic       src_ext;
    logic [3:0] pre_n;
    logic       pre_en;
  } src_cfg_t;

  typedef struct packed {
    logic wave_pol;
    logic wave_off;
    logic restart;
    logic cmp_en;
    logic down;
    logic interval;
    logic stop;
  } cnt_cfg_t;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tmr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tmr_en,
  input  logic     ext_clk,
  input  src_cfg_t cfg,
  input  logic     clear,
  output logic     adv
);
  localparam int NB = $bits(cfg.pre_n);
  localparam int PW = (1 << NB) + 1;

  logic          s1, s2, s3;
  logic          src_tick;
  logic          last;
  logic [PW-1:0] pcnt;
  logic [PW-1:0] lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= ext_clk;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_comb begin
    if (cfg.src_ext) src_tick = tmr_en & (cfg.edge_fall ? (s3 & ~s2) : (s2 & ~s3));
    else             src_tick = tmr_en;
  end

  assign lim  = (PW'(2) << cfg.pre_n) - PW'(1);
  assign last = !cfg.pre_en || (pcnt >= lim);
  assign adv  = src_tick && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pcnt <= '0;
    else if (clear)    pcnt <= '0;
    else if (src_tick) pcnt <= last ? '0 : pcnt + PW'(1);
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  cnt_cfg_t      cfg,
  input  logic          load,
  input  logic          load_down,
  input  logic [CW-1:0] intv,
  output logic [CW-1:0] count,
  output logic [CW-1:0] nxt,
  output logic          step,
  output logic          ev_wrap,
  output logic          ev_ovf
);
  localparam logic [CW-1:0] CMAX = '1;

  always_comb begin
    nxt     = count;
    ev_wrap = 1'b0;
    ev_ovf  = 1'b0;
    step    = adv && !cfg.stop && !load;
    if (step) begin
      if (cfg.down) begin
        if (count == '0) begin
          if (cfg.interval) begin
            nxt     = intv;
            ev_wrap = 1'b1;
          end else begin
            nxt    = CMAX;
            ev_ovf = 1'b1;
          end
        end else begin
          nxt = count - CW'(1);
        end
      end else begin
        if (cfg.interval && count >= intv) begin
          nxt     = '0;
          ev_wrap = 1'b1;
        end else if (!cfg.interval && count == CMAX) begin
          nxt    = '0;
          ev_ovf = 1'b1;
        end else begin
          nxt = count + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_down ? intv : '0;
    else           count <= nxt;
  end
endmodule

// File: rtl/tmr_cmp_bank.sv
module tmr_cmp_bank
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                       step,
  input  logic                       enable,
  input  logic [CW-1:0]              nxt,
  input  logic [NUM_CMP-1:0][CW-1:0] cmp,
  output logic [NUM_CMP-1:0]         hit
);
  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    assign hit[i] = step && enable && (nxt == cmp[i]);
  end
endmodule

// File: rtl/tmr_match_chan.sv
module tmr_match_chan
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          bus_rvalid,
  input  logic          tmr_en,
  input  logic          ext_clk,
  output logic          irq,
  output logic          wave_out
);
  src_cfg_t                   src_q;
  cnt_cfg_t                   ctl_q;
  cnt_cfg_t                   ctl_wd;
  logic [CW-1:0]              intv_q;
  logic [NUM_CMP-1:0][CW-1:0] cmp_q;
  logic [NUM_EV-1:0]          stat_q, mask_q, ev;
  logic [NUM_CMP-1:0]         hit;
  logic [CW-1:0]              count, nxt, rd_mux;
  logic                       adv, step, ev_wrap, ev_ovf;
  logic                       ctl_wr, load, stat_rd, wave_q;

  assign ctl_wd  = cnt_cfg_t'(bus_wdata[6:0]);
  assign ctl_wr  = bus_wr && (bus_addr == A_CTL);
  assign load    = ctl_wr && ctl_wd.restart;
  assign stat_rd = bus_rd && (bus_addr == A_STAT);

  tmr_tick_gen u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .tmr_en  (tmr_en),
    .ext_clk (ext_clk),
    .cfg     (src_q),
    .clear   (load),
    .adv     (adv)
  );

  tmr_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .cfg       (ctl_q),
    .load      (load),
    .load_down (ctl_wd.down),
    .intv      (intv_q),
    .count     (count),
    .nxt       (nxt),
    .step      (step),
    .ev_wrap   (ev_wrap),
    .ev_ovf    (ev_ovf)
  );

  tmr_cmp_bank #(.CW(CW)) u_cmp (
    .step   (step),
    .enable (ctl_q.cmp_en),
    .nxt    (nxt),
    .cmp    (cmp_q),
    .hit    (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      ctl_q  <= cnt_cfg_t'(CTL_RST);
      intv_q <= '0;
      mask_q <= '0;
      cmp_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_SRC)  src_q  <= src_cfg_t'(bus_wdata[6:0]);
      if (ctl_wr) begin
        ctl_q         <= ctl_wd;
        ctl_q.restart <= 1'b0;
      end
      if (bus_addr == A_INTV) intv_q <= bus_wdata;
      if (bus_addr == A_MASK) mask_q <= bus_wdata[NUM_EV-1:0];
      for (int i = 0; i < NUM_CMP; i++) begin
        if (bus_addr == A_CMP0 + 8'(CMP_STRIDE * i)) cmp_q[i] <= bus_wdata;
      end
    end
  end

  assign ev = {ev_ovf, hit, ev_wrap};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      wave_q <= 1'b0;
    end else begin
      stat_q <= (stat_rd ? '0 : stat_q) | ev;
      if (hit[0]) wave_q <= ~wave_q;
    end
  end

  assign irq      = |(stat_q & mask_q);
  assign wave_out = !ctl_q.wave_off && (wave_q ^ ctl_q.wave_pol);

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_SRC:   rd_mux = CW'(src_q);
      A_CTL:   rd_mux = CW'(ctl_q);
      A_CNT:   rd_mux = count;
      A_INTV:  rd_mux = intv_q;
      A_STAT:  rd_mux = CW'(stat_q);
      A_MASK:  rd_mux = CW'(mask_q);
      default: rd_mux = '0;
    endcase
    for (int i = 0; i < NUM_CMP; i++) begin
      if (bus_addr == A_CMP0 + 8'(CMP_STRIDE * i)) rd_mux = cmp_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/tmr_match_chan_chk.sv
module tmr_match_chan_chk
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [7:0]    bus_addr,
  input logic          wd_restart,
  input logic          wd_down,
  input logic          bus_rvalid,
  input logic          adv,
  input logic          c_stop,
  input logic          c_down,
  input logic          c_interval,
  input logic [CW-1:0] count,
  input logic [CW-1:0] intv,
  input logic [NUM_EV-1:0] stat
);
  logic ctl_wr;
  assign ctl_wr = bus_wr && (bus_addr == A_CTL);

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    c_stop && !ctl_wr |=> $stable(count)); // R3

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !c_stop && c_down && (count != '0) && !ctl_wr
    |=> count == CW'($past(count) - CW'(1))); // R4

  AST_INTERVAL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !c_stop && c_interval && !c_down && (count == intv) && !ctl_wr
    |=> count == '0); // R6

  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && wd_restart && !wd_down |=> count == '0); // R7

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_addr == A_STAT) |=> (stat & $past(stat)) == $past(stat)); // R11

  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid); // R2
endmodule

bind tmr_match_chan tmr_match_chan_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .wd_restart (bus_wdata[4]),
  .wd_down    (bus_wdata[2]),
  .bus_rvalid (bus_rvalid),
  .adv        (adv),
  .c_stop     (ctl_q.stop),
  .c_down     (ctl_q.down),
  .c_interval (ctl_q.interval),
  .count      (count),
  .intv       (intv_q),
  .stat       (stat_q)
);

// File: tb/tmr_match_chan_test.sv
module tmr_match_chan_test;
  localparam int CLK_T = 10;
  localparam int CW = 16;

  typedef struct packed {
    logic [7:0]  src;
    logic [7:0]  ctl;
    logic [15:0] intv;
    logic [31:0] n;
    logic [15:0] cnt;
    logic [4:0]  stat;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 8'h10, 16'd0, 32'd5,  16'd5,     5'h00},  // R3 up count
    '{8'h00, 8'h12, 16'd3, 32'd6,  16'd2,     5'h01},  // R6 interval up
    '{8'h00, 8'h16, 16'd4, 32'd6,  16'd3,     5'h01},  // R6 R4 interval down
    '{8'h00, 8'h14, 16'd0, 32'd2,  16'hFFFE,  5'h10},  // R4 R5 down overflow
    '{8'h03, 8'h10, 16'd0, 32'd10, 16'd2,     5'h00},  // R8 N=1
    '{8'h01, 8'h10, 16'd0, 32'd7,  16'd3,     5'h00},  // R8 N=0
    '{8'h00, 8'h11, 16'd0, 32'd5,  16'd0,     5'h00}   // R3 stopped
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [CW-1:0] bus_wdata = '0;
  logic [CW-1:0] bus_rdata;
  logic          bus_rvalid, tmr_en = 1'b0, ext_clk = 1'b0, irq, wave_out;
  int checks = 0, errors = 0;
  logic [CW-1:0] rv;

  tmr_match_chan #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .tmr_en(tmr_en), .ext_clk(ext_clk),
    .irq(irq), .wave_out(wave_out)
  );

  always #(CLK_T/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [CW-1:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    tmr_en = 1'b1;
    repeat (n) @(negedge clk);
    tmr_en = 1'b0;
  endtask

  task automatic ext_level(input logic v);
    ext_clk = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_T * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h0C, rv); chk("R1 ctl reset", 32'(rv), 32'h21);
    rd(8'h18, rv); chk("R1 count reset", 32'(rv), 0);
    rd(8'h54, rv); chk("R1 status reset", 32'(rv), 0);
    chk("R1 irq reset", 32'(irq), 0);
    chk("R1 wave reset", 32'(wave_out), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr(8'h24, VEC[i].intv);
      wr(8'h00, CW'(VEC[i].src));
      wr(8'h0C, CW'(VEC[i].ctl));
      rd(8'h54, rv);
      pulse(int'(VEC[i].n));
      rd(8'h18, rv); chk($sformatf("vec%0d count R3 R4 R8", i), 32'(rv), 32'(VEC[i].cnt));
      rd(8'h54, rv); chk($sformatf("vec%0d status R5 R6", i), 32'(rv), 32'(VEC[i].stat));
      rd(8'h0C, rv); chk($sformatf("vec%0d R7 ctl readback", i), 32'(rv), 32'(VEC[i].ctl & 8'hEF));
    end

    // R5 full-width up overflow
    wr(8'h00, 0); wr(8'h0C, 16'h10); rd(8'h54, rv);
    pulse(65537);
    rd(8'h18, rv); chk("R5 up overflow count", 32'(rv), 1);
    rd(8'h54, rv); chk("R5 up overflow status", 32'(rv), 32'h10);

    // R2 count is read-only, compare readback
    wr(8'h18, 16'h1234);
    rd(8'h18, rv); chk("R2 count write ignored", 32'(rv), 1);
    wr(8'h3C, 16'd5);
    rd(8'h3C, rv); chk("R2 compare1 readback", 32'(rv), 5);

    // R10 R12 R13 compare behaviour
    wr(8'h24, 16'd9); wr(8'h30, 16'd3); wr(8'h48, 16'd20);
    wr(8'h60, 16'h02); wr(8'h0C, 16'h1A); rd(8'h54, rv);
    pulse(4);
    chk("R13 wave toggled", 32'(wave_out), 1);
    chk("R12 irq on enabled bit", 32'(irq), 1);
    rd(8'h54, rv); chk("R10 compare0 status", 32'(rv), 32'h02);
    chk("R11 irq cleared after read", 32'(irq), 0);
    rd(8'h54, rv); chk("R11 status cleared", 32'(rv), 0);
    pulse(2);
    chk("R12 masked bit no irq", 32'(irq), 0);
    rd(8'h54, rv); chk("R10 compare1 status", 32'(rv), 32'h04);
    pulse(7);
    rd(8'h54, rv); chk("R10 R6 wrap plus compare0", 32'(rv), 32'h03);
    chk("R13 wave toggled back", 32'(wave_out), 0);
    wr(8'h0C, 16'h4A); chk("R13 polarity", 32'(wave_out), 1);
    wr(8'h0C, 16'h6A); chk("R13 forced low", 32'(wave_out), 0);

    // R10 compare disabled
    wr(8'h0C, 16'h12); rd(8'h54, rv);
    pulse(4);
    rd(8'h54, rv); chk("R10 no status without enable", 32'(rv), 0);
    chk("R13 wave unchanged", 32'(wave_out), 0);

    // R9 external rising edges: 3 rises, 2 falls
    wr(8'h00, 16'h20); wr(8'h0C, 16'h10);
    @(negedge clk); tmr_en = 1'b1;
    ext_level(1); ext_level(0); ext_level(1); ext_level(0); ext_level(1);
    tmr_en = 1'b0;
    rd(8'h18, rv); chk("R9 rising edges", 32'(rv), 3);

    // R9 external falling edges: 3 falls, 2 rises
    wr(8'h00, 16'h60); wr(8'h0C, 16'h10);
    @(negedge clk); tmr_en = 1'b1;
    ext_level(0); ext_level(1); ext_level(0); ext_level(1); ext_level(0);
    tmr_en = 1'b0;
    rd(8'h18, rv); chk("R9 falling edges", 32'(rv), 3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule